// File: doc/BRIEF.md
# Inbound Requester Partition Resolver

This block sits on the inbound side of a PCIe host bridge and decides which isolation partition owns each arriving request. The requester ID (bus/device/function) of every DMA, MSI write or error message indexes an on-chip partition table, and the partition number comes back one clock later. For DMA, one fixed high address bit picks between the two address windows the partition owns. For MSI writes, the address is first tested against two MSI windows. A hit is turned into one of 2048 interrupt sources, and the owner recorded in that source's descriptor must equal the requester's partition before the interrupt is let through.

Both tables are loaded through one configuration write port, with a target bit that chooses between them. An MSI that hits a window but fails the ownership test is dropped. It also latches a sticky violation flag together with the offending requester ID, and both hold until reset. Error messages only pick up the partition number. This block performs no further decoding of them.

Top module: `req_part_lookup`

## Requirements
- R1: After reset, rsp_valid, rsp_irq_valid and viol_flag are 0 and viol_rid is 0.
- R2: A request accepted in one cycle appears on the response outputs in the next cycle. rsp_part equals the partition table entry indexed by the low RTT_AW bits of req_rid. A configuration write with cfg_tgt=0 loads that table at cfg_addr[RTT_AW-1:0].
- R3: If a configuration write and a lookup address the same table entry in the same cycle, the lookup returns the entry's previous contents. Lookups in later cycles return the new value.
- R4: Request kind 0 is DMA. For it, rsp_dma_win equals address bit 59 (DMA_SEL_BIT). For every other kind, rsp_dma_win is 0.
- R5: Request kind 1 is an MSI write. It hits when address bits 63..32 are zero and bits 31..16 are all ones (the low window). It also hits when address bits 63..16 equal msi_hi_base bits 63..16 (the high window). Any other address gives rsp_msi_hit=0 and no interrupt, and leaves the violation state unchanged.
- R6: The interrupt index is the sum of req_data[10:0] and req_addr[12:2], modulo 2048.
- R7: rsp_irq_valid is 1 only for an MSI window hit whose descriptor owner equals rsp_part. A configuration write with cfg_tgt=1 loads descriptor cfg_addr[10:0].
- R8: An MSI window hit that fails the owner test sets viol_flag in the following cycle and records its requester ID in viol_rid. Once set, both hold until reset, and later rejections do not change viol_rid.
- R9: Request kinds 2 (error message) and 3 return only rsp_part. rsp_msi_hit, rsp_irq_valid and rsp_dma_win are 0 for them.
- R10: rsp_kind echoes the request kind, and rsp_valid is 0 in any cycle after one with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_tgt | input | 1 | Write target: 0 partition table, 1 interrupt descriptors |
| cfg_addr | input | RID_W | Entry index for the write |
| cfg_data | input | PART_W | Partition number written |
| msi_hi_base | input | ADDR_W | Base of the high MSI window (bits above MSI_WIN_AW used) |
| req_valid | input | 1 | Inbound request present |
| req_kind | input | 2 | 0 DMA, 1 MSI write, 2 error message, 3 treated as 2 |
| req_rid | input | RID_W | Requester ID |
| req_addr | input | ADDR_W | Request address |
| req_data | input | DATA_W | MSI write data |
| rsp_valid | output | 1 | Response valid |
| rsp_kind | output | 2 | Echoed request kind |
| rsp_part | output | PART_W | Partition number from the table |
| rsp_dma_win | output | 1 | DMA window select |
| rsp_msi_hit | output | 1 | MSI address hit one of the windows |
| rsp_irq_valid | output | 1 | Authorized interrupt |
| rsp_irq_idx | output | IRQ_W | Interrupt source index |
| viol_flag | output | 1 | Sticky ownership violation |
| viol_rid | output | RID_W | Requester ID of the first violation |

## Verification
Two pairs of functions can land in the same cycle. A configuration write can hit the partition entry that a lookup reads at that moment. A rejected MSI's violation update can also coincide with the next request's lookup. The bench provokes the first by driving a table write and a request to the same entry together. It expects the old partition number, then the new one a request later. The random phase mixes concurrent writes into MSI traffic so that the violation flag is compared against a bench model after every response.

// File: rtl/req_part_lookup.sv
module req_part_lookup #(
  parameter int RID_W       = 16,
  parameter int RTT_AW      = 8,
  parameter int PART_W      = 8,
  parameter int IRQ_W       = 11,
  parameter int ADDR_W      = 64,
  parameter int DATA_W      = 32,
  parameter int MSI_WIN_AW  = 16,
  parameter int DMA_SEL_BIT = 59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_tgt,
  input  logic [RID_W-1:0]  cfg_addr,
  input  logic [PART_W-1:0] cfg_data,
  input  logic [ADDR_W-1:0] msi_hi_base,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [RID_W-1:0]  req_rid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [PART_W-1:0] rsp_part,
  output logic              rsp_dma_win,
  output logic              rsp_msi_hit,
  output logic              rsp_irq_valid,
  output logic [IRQ_W-1:0]  rsp_irq_idx,
  output logic              viol_flag,
  output logic [RID_W-1:0]  viol_rid
);
  localparam int RTT_N = 1 << RTT_AW;
  localparam int IRQ_N = 1 << IRQ_W;
  localparam logic [1:0] K_DMA = 2'd0;
  localparam logic [1:0] K_MSI = 2'd1;

  logic [PART_W-1:0] rtt_mem [RTT_N];
  logic [PART_W-1:0] own_mem [IRQ_N];
  logic [PART_W-1:0] own_q;
  logic [RID_W-1:0]  s1_rid;

  logic                  lo_hit, hi_hit;
  logic [MSI_WIN_AW-3:0] win_off;
  logic [IRQ_W-1:0]      irq_c;
  logic                  own_ok;

  assign lo_hit  = (req_addr[ADDR_W-1:32] == '0) && (&req_addr[31:MSI_WIN_AW]);
  assign hi_hit  = req_addr[ADDR_W-1:MSI_WIN_AW] == msi_hi_base[ADDR_W-1:MSI_WIN_AW];
  assign win_off = req_addr[MSI_WIN_AW-1:2];
  assign irq_c   = req_data[IRQ_W-1:0] + win_off[IRQ_W-1:0];

  logic unused_bits;
  assign unused_bits = ^{req_data[DATA_W-1:IRQ_W], req_addr[1:0],
                         msi_hi_base[MSI_WIN_AW-1:0], cfg_addr[RID_W-1:IRQ_W]};

  always_ff @(posedge clk) begin
    if (cfg_we && !cfg_tgt) rtt_mem[cfg_addr[RTT_AW-1:0]] <= cfg_data;
    if (cfg_we && cfg_tgt)  own_mem[cfg_addr[IRQ_W-1:0]]  <= cfg_data;
    rsp_part <= rtt_mem[req_rid[RTT_AW-1:0]];
    own_q    <= own_mem[irq_c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_kind    <= '0;
      rsp_dma_win <= 1'b0;
      rsp_msi_hit <= 1'b0;
      rsp_irq_idx <= '0;
      s1_rid      <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_kind    <= req_kind;
        rsp_dma_win <= (req_kind == K_DMA) && req_addr[DMA_SEL_BIT];
        rsp_msi_hit <= (req_kind == K_MSI) && (lo_hit || hi_hit);
        rsp_irq_idx <= irq_c;
        s1_rid      <= req_rid;
      end
    end
  end

  assign own_ok        = own_q == rsp_part;
  assign rsp_irq_valid = rsp_valid && rsp_msi_hit && own_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_flag <= 1'b0;
      viol_rid  <= '0;
    end else if (rsp_valid && rsp_msi_hit && !own_ok && !viol_flag) begin
      viol_flag <= 1'b1;
      viol_rid  <= s1_rid;
    end
  end
endmodule

module req_part_lookup_chk #(
  parameter int RID_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic [1:0]       rsp_kind,
  input logic             rsp_dma_win,
  input logic             rsp_msi_hit,
  input logic             rsp_irq_valid,
  input logic             viol_flag,
  input logic [RID_W-1:0] viol_rid
);
  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R7
  irq_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_irq_valid |-> (rsp_valid && rsp_msi_hit && rsp_kind == 2'd1));
  // R4
  dma_win_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_dma_win |-> rsp_kind == 2'd0);
  // R9
  msi_hit_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_msi_hit |-> rsp_kind == 2'd1);
  // R8
  reject_sets_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_msi_hit && !rsp_irq_valid) |=> viol_flag);
  // R8
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag |=> (viol_flag && $stable(viol_rid)));
endmodule

bind req_part_lookup req_part_lookup_chk #(.RID_W(RID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_kind(rsp_kind), .rsp_dma_win(rsp_dma_win), .rsp_msi_hit(rsp_msi_hit),
  .rsp_irq_valid(rsp_irq_valid), .viol_flag(viol_flag), .viol_rid(viol_rid)
);

// File: tb/req_part_lookup_tb_top.sv
`timescale 1ns/1ps
module req_part_lookup_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_tgt = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic [63:0] msi_hi_base = 64'h0000_0040_0000_0000;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [15:0] req_rid = '0;
  logic [63:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic        rsp_valid, rsp_dma_win, rsp_msi_hit, rsp_irq_valid, viol_flag;
  logic [1:0]  rsp_kind;
  logic [7:0]  rsp_part;
  logic [10:0] rsp_irq_idx;
  logic [15:0] viol_rid;

  req_part_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tgt(cfg_tgt), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .msi_hi_base(msi_hi_base), .req_valid(req_valid),
    .req_kind(req_kind), .req_rid(req_rid), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_part(rsp_part),
    .rsp_dma_win(rsp_dma_win), .rsp_msi_hit(rsp_msi_hit), .rsp_irq_valid(rsp_irq_valid),
    .rsp_irq_idx(rsp_irq_idx), .viol_flag(viol_flag), .viol_rid(viol_rid)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] rtt_sh [256];
  logic [7:0] own_sh [2048];
  bit         m_viol = 0;
  logic [15:0] m_vrid = '0;

  task automatic chk(string r, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  function automatic bit in_win(logic [63:0] a);
    return (a[63:32] == 32'h0 && a[31:16] == 16'hFFFF) || (a[63:16] == msi_hi_base[63:16]);
  endfunction

  function automatic logic [10:0] irq_of(logic [63:0] a, logic [31:0] d);
    return 11'(d[10:0] + a[12:2]);
  endfunction

  task automatic cfg_wr(bit tgt, int a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tgt = tgt; cfg_addr = 16'(a); cfg_data = d;
    if (tgt) own_sh[a[10:0]] = d; else rtt_sh[a[7:0]] = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic txn(logic [1:0] k, logic [15:0] rid, logic [63:0] a, logic [31:0] d,
                     bit wr, bit wtgt, int waddr, logic [7:0] wdata);
    logic [7:0]  e_part;
    logic [10:0] e_idx;
    bit          e_hit, e_irq, e_dw;
    @(negedge clk);
    chk("R10 idle rsp_valid", rsp_valid, 0);
    chk("R8 viol_flag", viol_flag, m_viol);
    chk("R8 viol_rid", viol_rid, m_vrid);
    req_valid = 1'b1; req_kind = k; req_rid = rid; req_addr = a; req_data = d;
    e_part = rtt_sh[rid[7:0]];
    e_idx  = irq_of(a, d);
    e_hit  = (k == 2'd1) && in_win(a);
    e_irq  = e_hit && (own_sh[e_idx] == e_part);
    e_dw   = (k == 2'd0) && a[59];
    if (wr) begin
      cfg_we = 1'b1; cfg_tgt = wtgt; cfg_addr = 16'(waddr); cfg_data = wdata;
      if (wtgt) own_sh[waddr[10:0]] = wdata; else rtt_sh[waddr[7:0]] = wdata;
    end
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    chk("R10 rsp_valid", rsp_valid, 1);
    chk("R10 rsp_kind", rsp_kind, k);
    chk("R2 rsp_part", rsp_part, e_part);
    chk(k >= 2 ? "R9 dma_win" : "R4 dma_win", rsp_dma_win, e_dw);
    chk(k >= 2 ? "R9 msi_hit" : "R5 msi_hit", rsp_msi_hit, e_hit);
    chk(k >= 2 ? "R9 irq_valid" : "R7 irq_valid", rsp_irq_valid, e_irq);
    if (e_hit) chk("R6 irq_idx", rsp_irq_idx, e_idx);
    if (e_hit && !e_irq && !m_viol) begin m_viol = 1; m_vrid = rid; end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 irq_valid", rsp_irq_valid, 0);
    chk("R1 viol_flag", viol_flag, 0);
    chk("R1 viol_rid", viol_rid, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) cfg_wr(0, i, 8'($urandom % 4));
    for (int i = 0; i < 2048; i++) cfg_wr(1, i, 8'($urandom % 4));

    // R3: write and lookup of the same entry in one cycle
    cfg_wr(0, 5, 8'h11);
    txn(2'd2, 16'h0305, 64'h0, 32'h0, 1, 0, 5, 8'h22);
    txn(2'd2, 16'h0005, 64'h0, 32'h0, 0, 0, 0, 8'h0);
    chk("R3 new value", rsp_part, 8'h22);

    // R4: both DMA windows, and kind 3
    txn(2'd0, 16'h0105, 64'h0800_0000_0000_1000, 32'h0, 0, 0, 0, 8'h0);
    txn(2'd0, 16'h0105, 64'h0000_0000_0000_1000, 32'h0, 0, 0, 0, 8'h0);
    txn(2'd3, 16'h0105, 64'h0800_0000_FFFF_0000, 32'h5, 0, 0, 0, 8'h0);

    // R7 matching owner, R6 wrap of index (0x7FF + 1 -> 0)
    cfg_wr(0, 8'h10, 8'h03);
    cfg_wr(1, 0, 8'h03);
    txn(2'd1, 16'h0010, 64'h0000_0000_FFFF_0004, 32'h7FF, 0, 0, 0, 8'h0);
    chk("R6 wrap idx", rsp_irq_idx, 11'd0);
    chk("R7 matched irq", rsp_irq_valid, 1);
    // R5: window miss leaves violation state alone
    cfg_wr(1, 8, 8'h01);
    txn(2'd1, 16'h0010, 64'h0000_0000_FFFE_0000, 32'h8, 0, 0, 0, 8'h0);
    // R8: two rejections, first RID kept
    txn(2'd1, 16'h0A10, 64'h0000_0040_0000_0000, 32'h8, 0, 0, 0, 8'h0);
    txn(2'd1, 16'h0B10, 64'h0000_0000_FFFF_0000, 32'h8, 0, 0, 0, 8'h0);
    @(negedge clk);
    chk("R8 first rid", viol_rid, 16'h0A10);

    for (int n = 0; n < 400; n++) begin
      logic [63:0] a;
      int c = $urandom % 4;
      a = {$urandom, $urandom};
      if (c == 0) a = {32'h0, 16'hFFFF, a[15:0]};
      else if (c == 1) a = {msi_hi_base[63:16], a[15:0]};
      else if (c == 2) a = {16'hABCD, a[47:0]};
      txn(2'($urandom), 16'($urandom), a, $urandom, ($urandom % 3) == 0,
          1'($urandom), int'($urandom % 2048), 8'($urandom % 4));
    end
    @(negedge clk);
    chk("R8 final viol_flag", viol_flag, m_viol);
    chk("R8 final viol_rid", viol_rid, m_vrid);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule